// File: doc/BRIEF.md
# Parallel Word Bitslip Aligner

This block re-aligns words that an upstream deserializer has already converted to parallel form. It runs entirely at the word clock. It keeps the previous word and the current word, and it picks a word-wide window out of the pair. Moving that window by one bit has the same effect as slipping the serial stream by one bit. The chosen offset is kept for every word that follows, so two slips look like a two-bit shift of the data.

The word width is a parameter of 4 or 8. The ports are always 8 bits wide, and in 4-bit operation only the low nibble carries meaning. An optional input register can be added, at the cost of one word of latency.

A mode parameter picks how the offset is steered:
- **Step mode:** a slip request moves the offset by one.
- **Count mode:** a loaded count of slips is applied first, and then the data is released.
- **Seek mode:** the block hunts through the offsets until the aligned word equals a given pattern, and then releases the data.

Top module: `bitslip_aligner`

## Requirements
- R1: With the offset at 0 and no input register, a word on `din` at clock edge t appears unchanged on `dout` after edge t+1. Setting `IN_REG` to 1 adds exactly one edge to this latency.
- R2: Only `din[WIDTH-1:0]` and `pattern[WIDTH-1:0]` are used. When WIDTH is 4, `dout[7:4]` is always zero, and the upper bits of `din` and `pattern` have no effect.
- R3: At offset k, the word released is ((newer << k) | (older >> (WIDTH-k))) truncated to WIDTH bits. Here newer and older are the two most recently captured words.
- R4: Each slip adds exactly one to the offset. The offset wraps modulo WIDTH and stays in place until the next slip, so a constant input word comes out rotated left by the total number of slips.
- R5: A synchronous active-high `rst` clears `dout`, `flag` and the offset. While `en` is low, no register changes: `dout`, `flag`, the offset and the captured words all hold, and a request made in that time is not seen.
- R6: In step mode, each rising edge of `slip_req` (sampled while `en` is high) causes one slip. The new offset shows on `dout` one edge after the slip. Holding `slip_req` high for several cycles causes a single slip.
- R7: In step mode, slips are counted modulo 8. `flag` is high for exactly one cycle on the edge that performs every eighth slip.
- R8: In count mode, a rising edge of `slip_req` loads `slip_cnt` (0 to 7) and starts a run. The run applies one slip per clock until that many slips are done. During the run `dout` and `flag` are zero. Afterwards `flag` stays high and `dout` carries the aligned words. A new edge restarts the run. From reset until the first run completes, `dout` and `flag` are zero.
- R9: In seek mode, a search starts at reset and again on each rising edge of `slip_req`. Each new offset first gets one settling cycle. On the next cycle the aligned word is compared with `pattern`: on a match, `flag` goes high and stays high and data is released; on a miss, the block slips once. `dout` is zero while the search runs, and a pattern that never matches keeps the search cycling through all offsets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Clock enable for the whole block, active high |
| din | input | 8 | Deserialized word (low WIDTH bits used) |
| slip_req | input | 1 | Slip request (step mode), load strobe (count mode), search restart (seek mode) |
| slip_cnt | input | 3 | Number of slips for a count-mode run |
| pattern | input | 8 | Target word for seek mode (low WIDTH bits used) |
| dout | output | 8 | Aligned word, registered |
| flag | output | 1 | Eighth-slip pulse (step mode), done level (count and seek modes) |

## Verification
Three instances share one stimulus: step mode at width 8, count mode at width 8 with the input register, and seek mode at width 4.

Random words with no slips show that the plain pipeline passes data unchanged. A constant word such as 0x81 then makes every offset readable as a rotation, which separates a correct window from one that is mirrored or off by one. Single pulses, a held request and a pulse made while the block is disabled tell edge detection apart from level sensing and from enable gating.

For seek mode, a constant 0x52 with the target 0xF8 checks both the match and that the upper bits of the pattern are ignored. The unmatched target 0xFF shows that the search keeps running with the output held at zero.

// File: rtl/bitslip_pkg.sv
package bitslip_pkg;
  localparam int PORT_W = 8;
  localparam int CNT_W  = 3;

  typedef enum logic [1:0] {
    SLIP_STEP  = 2'd0,
    SLIP_COUNT = 2'd1,
    SLIP_SEEK  = 2'd2
  } slip_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } seq_state_e;
endpackage

// File: rtl/bs_front.sv
// Optional input stage followed by the newer/older word pair.
module bs_front #(
  parameter int WIDTH  = 8,
  parameter bit IN_REG = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] newer,
  output logic [WIDTH-1:0] older
);
  logic [WIDTH-1:0] stage_in;

  generate
    if (IN_REG) begin : g_in_reg
      logic [WIDTH-1:0] in_q;
      always_ff @(posedge clk) begin
        if (rst)     in_q <= '0;
        else if (en) in_q <= din;
      end
      assign stage_in = in_q;
    end else begin : g_no_in_reg
      assign stage_in = din;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      newer <= '0;
      older <= '0;
    end else if (en) begin
      newer <= stage_in;
      older <= newer;
    end
  end
endmodule

// File: rtl/bs_window.sv
// Selects a WIDTH-bit window out of {newer, older} at the given offset.
module bs_window #(
  parameter int WIDTH = 8,
  localparam int OFF_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] newer,
  input  logic [WIDTH-1:0] older,
  input  logic [OFF_W-1:0] offset,
  output logic [WIDTH-1:0] aligned
);
  logic [2*WIDTH-1:0] pair;
  logic [WIDTH-1:0]   cand [WIDTH];

  assign pair = {newer, older};

  generate
    for (genvar j = 0; j < WIDTH; j++) begin : g_cand
      assign cand[j] = pair[WIDTH-j +: WIDTH];
    end
  endgenerate

  assign aligned = cand[offset];
endmodule

// File: rtl/bs_ctrl.sv
// Offset sequencer; the mode parameter picks one of three controllers.
module bs_ctrl
  import bitslip_pkg::*;
#(
  parameter int         WIDTH = 8,
  parameter slip_mode_e MODE  = SLIP_STEP,
  localparam int OFF_W = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             req,
  input  logic [CNT_W-1:0] cnt,
  input  logic [WIDTH-1:0] pattern,
  input  logic [WIDTH-1:0] aligned,
  output logic [OFF_W-1:0] offset,
  output logic             out_on,
  output logic             flag_d,
  output logic             req_q
);
  logic req_rise;

  always_ff @(posedge clk) begin
    if (rst)     req_q <= 1'b0;
    else if (en) req_q <= req;
  end
  assign req_rise = req & ~req_q;

  generate
    if (MODE == SLIP_STEP) begin : g_step
      logic [2:0] nslip;
      logic       unused_step;
      assign unused_step = ^{cnt, pattern, aligned};

      always_ff @(posedge clk) begin
        if (rst) begin
          offset <= '0;
          nslip  <= '0;
        end else if (en && req_rise) begin
          offset <= offset + OFF_W'(1);
          nslip  <= nslip + 3'd1;
        end
      end
      assign out_on = 1'b1;
      assign flag_d = req_rise & (&nslip);

    end else if (MODE == SLIP_COUNT) begin : g_count
      seq_state_e       state;
      logic [CNT_W-1:0] remain;
      logic             unused_count;
      assign unused_count = ^{pattern, aligned};

      always_ff @(posedge clk) begin
        if (rst) begin
          state  <= ST_IDLE;
          remain <= '0;
          offset <= '0;
        end else if (en) begin
          if (req_rise) begin
            state  <= ST_RUN;
            remain <= cnt;
          end else if (state == ST_RUN) begin
            if (remain != '0) begin
              offset <= offset + OFF_W'(1);
              remain <= remain - CNT_W'(1);
            end else begin
              state <= ST_DONE;
            end
          end
        end
      end
      assign out_on = (state == ST_DONE);
      assign flag_d = out_on;

    end else begin : g_seek
      seq_state_e state;
      logic       settle;
      logic       unused_seek;
      assign unused_seek = ^cnt;

      always_ff @(posedge clk) begin
        if (rst) begin
          state  <= ST_RUN;
          settle <= 1'b1;
          offset <= '0;
        end else if (en) begin
          if (req_rise) begin
            state  <= ST_RUN;
            settle <= 1'b1;
          end else if (state == ST_RUN) begin
            if (settle) begin
              settle <= 1'b0;
            end else if (aligned == pattern) begin
              state <= ST_DONE;
            end else begin
              offset <= offset + OFF_W'(1);
              settle <= 1'b1;
            end
          end
        end
      end
      assign out_on = (state == ST_DONE);
      assign flag_d = out_on;
    end
  endgenerate
endmodule

// File: rtl/bitslip_aligner.sv
module bitslip_aligner
  import bitslip_pkg::*;
#(
  parameter int         WIDTH  = 8,
  parameter bit         IN_REG = 1'b0,
  parameter slip_mode_e MODE   = SLIP_STEP
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [PORT_W-1:0] din,
  input  logic              slip_req,
  input  logic [CNT_W-1:0]  slip_cnt,
  input  logic [PORT_W-1:0] pattern,
  output logic [PORT_W-1:0] dout,
  output logic              flag
);
  localparam int OFF_W = $clog2(WIDTH);

  logic [WIDTH-1:0] newer, older, aligned, dout_q;
  logic [OFF_W-1:0] offset;
  logic             out_on, flag_d, req_q, flag_q;

  bs_front #(.WIDTH(WIDTH), .IN_REG(IN_REG)) u_front (
    .clk(clk), .rst(rst), .en(en), .din(din[WIDTH-1:0]),
    .newer(newer), .older(older)
  );

  bs_window #(.WIDTH(WIDTH)) u_window (
    .newer(newer), .older(older), .offset(offset), .aligned(aligned)
  );

  bs_ctrl #(.WIDTH(WIDTH), .MODE(MODE)) u_ctrl (
    .clk(clk), .rst(rst), .en(en), .req(slip_req), .cnt(slip_cnt),
    .pattern(pattern[WIDTH-1:0]), .aligned(aligned),
    .offset(offset), .out_on(out_on), .flag_d(flag_d), .req_q(req_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dout_q <= '0;
      flag_q <= 1'b0;
    end else if (en) begin
      dout_q <= out_on ? aligned : '0;
      flag_q <= flag_d;
    end
  end

  assign dout = PORT_W'(dout_q);
  assign flag = flag_q;

  generate
    if (WIDTH < PORT_W) begin : g_narrow
      logic unused_hi;
      assign unused_hi = ^{din[PORT_W-1:WIDTH], pattern[PORT_W-1:WIDTH]};
    end
  endgenerate
endmodule

// File: rtl/bitslip_aligner_chk.sv
module bitslip_aligner_chk
  import bitslip_pkg::*;
#(
  parameter int         WIDTH = 8,
  parameter slip_mode_e MODE  = SLIP_STEP,
  localparam int OFF_W = $clog2(WIDTH)
) (
  input logic              clk,
  input logic              rst,
  input logic              en,
  input logic              slip_req,
  input logic [PORT_W-1:0] dout,
  input logic              flag,
  input logic [OFF_W-1:0]  offset,
  input logic              out_on,
  input logic              req_q
);
  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= armed | rst;

  // R4: the offset only ever moves forward by one, with wrap
  a_r4_single_step: assert property (@(posedge clk) disable iff (rst || !armed)
    (!$past(rst) && offset != $past(offset)) |-> (offset == $past(offset) + OFF_W'(1)));

  // R5: a disabled cycle changes nothing visible
  a_r5_hold_when_off: assert property (@(posedge clk) disable iff (rst || !armed)
    !en |=> ($stable(dout) && $stable(flag) && $stable(offset)));

  generate
    if (WIDTH < PORT_W) begin : g_narrow_chk
      // R2: unused upper output bits stay clear
      a_r2_upper_clear: assert property (@(posedge clk) disable iff (rst || !armed)
        dout[PORT_W-1:WIDTH] == '0);
    end

    if (MODE == SLIP_STEP) begin : g_step_chk
      // R6: a held request does not slip again
      a_r6_level_no_slip: assert property (@(posedge clk) disable iff (rst || !armed)
        (en && req_q && slip_req) |=> $stable(offset));
      // R7: the eighth-slip indication lasts one cycle
      a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst || !armed)
        (en && flag) |=> !flag);
    end else begin : g_seq_chk
      // R8/R9: output and flag stay low while the sequence runs
      a_r8_quiet_while_busy: assert property (@(posedge clk) disable iff (rst || !armed)
        (en && !out_on) |=> (dout == '0 && !flag));
    end
  endgenerate
endmodule

bind bitslip_aligner bitslip_aligner_chk #(.WIDTH(WIDTH), .MODE(MODE)) u_chk (
  .clk(clk), .rst(rst), .en(en), .slip_req(slip_req), .dout(dout),
  .flag(flag), .offset(offset), .out_on(out_on), .req_q(req_q)
);

// File: tb/tb_bitslip_aligner.sv
module tb_bitslip_aligner;
  import bitslip_pkg::*;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en = 1'b0;
  logic [7:0] din = 8'h00;
  logic       slip_req = 1'b0;
  logic [2:0] slip_cnt = 3'd0;
  logic [7:0] pattern = 8'h00;

  logic [7:0] dout_s, dout_n, dout_c;
  logic       flag_s, flag_n, flag_c;

  always #10 clk = ~clk;

  bitslip_aligner #(.WIDTH(8), .IN_REG(1'b0), .MODE(SLIP_STEP)) dut (
    .clk(clk), .rst(rst), .en(en), .din(din), .slip_req(slip_req),
    .slip_cnt(slip_cnt), .pattern(pattern), .dout(dout_s), .flag(flag_s));
  bitslip_aligner #(.WIDTH(8), .IN_REG(1'b1), .MODE(SLIP_COUNT)) dut_num (
    .clk(clk), .rst(rst), .en(en), .din(din), .slip_req(slip_req),
    .slip_cnt(slip_cnt), .pattern(pattern), .dout(dout_n), .flag(flag_n));
  bitslip_aligner #(.WIDTH(4), .IN_REG(1'b0), .MODE(SLIP_SEEK)) dut_cmp (
    .clk(clk), .rst(rst), .en(en), .din(din), .slip_req(slip_req),
    .slip_cnt(slip_cnt), .pattern(pattern), .dout(dout_c), .flag(flag_c));

  int n_checks = 0;
  int n_fail = 0;
  string phase = "R5";
  bit started = 1'b0;
  int cycles = 0;
  int flag_seen = 0;

  // Behavioural reference: a history of accepted words plus per-instance control
  int hist[$];
  int k[3], rq[3], ns[3], st[3], rem[3], stl[3], md[3], mf[3];

  function automatic int cfg_w(input int i);
    return (i == 2) ? 4 : 8;
  endfunction
  function automatic int cfg_ir(input int i);
    return (i == 1) ? 1 : 0;
  endfunction

  task automatic step(input int i);
    int w, mask, nw, od, al, rise, on;
    w = cfg_w(i);
    mask = (1 << w) - 1;
    if (rst) begin
      k[i] = 0; rq[i] = 0; ns[i] = 0; md[i] = 0; mf[i] = 0;
      st[i] = (i == 2) ? 1 : 0; rem[i] = 0; stl[i] = 1;
      return;
    end
    if (!en) return;
    nw = hist[hist.size() - 1 - cfg_ir(i)] & mask;
    od = hist[hist.size() - 2 - cfg_ir(i)] & mask;
    al = ((nw << k[i]) | (od >> (w - k[i]))) & mask;
    rise = (slip_req && !rq[i]) ? 1 : 0;
    on = (i == 0 || st[i] == 2) ? 1 : 0;
    md[i] = on ? al : 0;
    if (i == 0) begin
      mf[i] = (rise && ns[i] == 7) ? 1 : 0;
      if (rise) begin k[i] = (k[i] + 1) % w; ns[i] = (ns[i] + 1) % 8; end
    end else if (i == 1) begin
      mf[i] = (st[i] == 2) ? 1 : 0;
      if (rise) begin st[i] = 1; rem[i] = int'(slip_cnt); end
      else if (st[i] == 1) begin
        if (rem[i] > 0) begin k[i] = (k[i] + 1) % w; rem[i]--; end
        else st[i] = 2;
      end
    end else begin
      mf[i] = (st[i] == 2) ? 1 : 0;
      if (rise) begin st[i] = 1; stl[i] = 1; end
      else if (st[i] == 1) begin
        if (stl[i] != 0) stl[i] = 0;
        else if (al == (int'(pattern) & mask)) st[i] = 2;
        else begin k[i] = (k[i] + 1) % w; stl[i] = 1; end
      end
    end
    rq[i] = slip_req ? 1 : 0;
  endtask

  always @(posedge clk) begin
    cycles++;
    for (int i = 0; i < 3; i++) step(i);
    if (rst) begin
      hist.delete();
      for (int j = 0; j < 3; j++) hist.push_back(0);
    end else if (en) begin
      hist.push_back(int'(din));
      if (hist.size() > 4) void'(hist.pop_front());
    end
    started = 1'b1;
  end

  task automatic check(input string tag, input string what, input int got, input int exp);
    n_checks++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      check(phase, "step dout", int'(dout_s), md[0]);
      check(phase, "step flag", int'(flag_s), mf[0]);
      check(phase, "count dout", int'(dout_n), md[1]);
      check(phase, "count flag", int'(flag_n), mf[1]);
      check(phase, "seek dout", int'(dout_c), md[2]);
      check(phase, "seek flag", int'(flag_c), mf[2]);
      check("R2", "narrow upper bits", int'(dout_c[7:4]), 0);
      if (flag_s) flag_seen++;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input int gap);
    slip_req = 1'b1; cyc(1);
    slip_req = 1'b0; cyc(gap);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cycles > 20000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      finish_run();
    end
  end

  logic [7:0] held;

  initial begin
    cyc(3);
    // R5: reset state
    check("R5", "reset dout", int'(dout_s), 0);
    check("R5", "reset flag", int'(flag_n), 0);
    rst = 1'b0; en = 1'b1;

    phase = "R1";
    for (int i = 0; i < 16; i++) begin din = 8'($urandom_range(0, 255)); cyc(1); end
    din = 8'h3C; cyc(1);
    din = 8'hA5; cyc(1);
    check("R1", "pass-through first", int'(dout_s), 8'h3C);
    cyc(1);
    check("R1", "pass-through second", int'(dout_s), 8'hA5);

    phase = "R6";
    for (int i = 0; i < 3; i++) begin
      din = 8'($urandom_range(0, 255));
      pulse(4);
    end
    slip_req = 1'b1; cyc(6); slip_req = 1'b0;
    din = 8'h81; cyc(4);
    check("R3", "window at offset 4", int'(dout_s), 8'h18);

    phase = "R7";
    flag_seen = 0;
    for (int i = 0; i < 5; i++) pulse(3);
    cyc(2);
    check("R7", "eighth-slip pulses", flag_seen, 1);
    check("R4", "wrapped offset 1", int'(dout_s), 8'h03);

    phase = "R5";
    held = dout_s;
    en = 1'b0;
    din = 8'h5A; slip_req = 1'b1; cyc(1);
    din = 8'hC4; slip_req = 1'b0; cyc(2);
    check("R5", "disabled hold", int'(dout_s), int'(held));
    din = 8'h81; en = 1'b1; cyc(4);
    check("R5", "request ignored while off", int'(dout_s), 8'h03);

    phase = "R8";
    slip_cnt = 3'd5; slip_req = 1'b1; cyc(1); slip_req = 1'b0; cyc(1);
    check("R8", "busy flag", int'(flag_n), 0);
    check("R8", "busy dout", int'(dout_n), 0);
    cyc(10);
    check("R8", "done flag", int'(flag_n), 1);
    for (int i = 0; i < 6; i++) begin din = 8'($urandom_range(0, 255)); cyc(1); end
    slip_cnt = 3'd0; pulse(4);
    slip_cnt = 3'd7; pulse(12);
    check("R8", "done after seven", int'(flag_n), 1);

    phase = "R9";
    din = 8'h52; pattern = 8'hF8; cyc(4);
    pulse(20);
    check("R9", "match flag", int'(flag_c), 1);
    check("R9", "matched word", int'(dout_c), 8'h08);
    pattern = 8'hFF;
    pulse(20);
    check("R9", "no match flag", int'(flag_c), 0);
    check("R9", "no match dout", int'(dout_c), 0);
    cyc(2);
    finish_run();
  end
endmodule